// File: doc/BRIEF.md
# Setup/Hold Violation Detector

This block inspects an oversampled picture of a qualifying clock line and a group of data lines. Every cycle of the fast sample tick brings one sample of each line, and one tick is the finest timing step. When the sampled clock shows an active edge, the block checks whether any data line changed level inside a programmable window around that edge. It then reports the result as a per-edge pulse, a violation flag, and a mask with one bit per channel.

The window is described by two signed offsets in ticks: a setup bound and a hold bound. Each can sit before the edge (negative) or after it (positive), so the window can be shifted to either side of the edge. A history of transitions reaches PRE ticks into the past and POST ticks into the future. The verdict for an edge is therefore issued a fixed number of ticks after that edge, once the latest possible hold point has been seen. A saturating counter totals the edges that were found in violation.

Top module: `setup_hold_checker`

## Requirements
- R1: While rst_n is low, viol_valid, viol_flag, viol_mask and viol_count are all zero.
- R2: A transition on channel c at tick t means sample t of smp_data[c] differs from sample t-1. For an edge at tick E, viol_mask bit c is set if and only if channel c has a transition at offset k = t-E with cfg_setup <= k <= cfg_hold. Both bounds are two's-complement values of OFS_W bits.
- R3: Transitions at offsets below -PRE or above +POST never set a mask bit, whatever the bounds.
- R4: If cfg_setup is greater than cfg_hold, the window is empty: the result for that edge is still issued, but with a zero mask and a low flag.
- R5: viol_valid is high for exactly one cycle per detected edge. It is registered on the (POST+1)-th rising edge of clk after the edge that samples the new clock level; at all other times it is low and viol_mask and viol_flag are zero.
- R6: cfg_edge selects the edges that count: 2'b00 none, 2'b01 rising only, 2'b10 falling only, 2'b11 both. The edge tick is the first sample that shows the new level of smp_clk.
- R7: When viol_valid is high, viol_flag equals the OR of viol_mask.
- R8: viol_count increases by one with each result whose flag is high. It holds its value otherwise and stays at 2^CNT_W-1 once it gets there.
- R9: The first sample after reset only serves as the reference for later samples. It never forms a clock edge or a data transition.
- R10: A pulse two ticks wide is detected when either of its level changes falls inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_clk | input | 1 | Sampled qualifying clock line |
| smp_data | input | NCH | Sampled data lines |
| cfg_edge | input | 2 | Active edge selection |
| cfg_setup | input | OFS_W | Signed window start offset, ticks |
| cfg_hold | input | OFS_W | Signed window end offset, ticks |
| viol_valid | output | 1 | One-cycle result strobe per edge |
| viol_flag | output | 1 | Some channel violated the window |
| viol_mask | output | NCH | Per-channel violation bits |
| viol_count | output | CNT_W | Saturating count of violating edges |

## Verification
The bench builds the block with NCH=4, PRE=8, POST=8, OFS_W=5 and CNT_W=6. With a history of only 17 ticks, it can sweep every pair of bounds from -9 to +9, including all empty windows. Across that sweep, the transition offsets cover -9 to +10, so both edges of the look range and the cases just outside it are exercised. The 6-bit counter reaches saturation within the sweep, which makes the hold at its maximum observable.

// File: rtl/shd_pkg.sv
package shd_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/shd_front.sv
// Registers the previous sample and turns the stream into edge and transition events.
module shd_front #(
   parameter int NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_clk,
   input  logic [NCH-1:0] smp_data,
   input  logic [1:0]     cfg_edge,
   output logic           edge_hit,
   output logic [NCH-1:0] trans
);
   import shd_pkg::*;

   logic           primed;
   logic           clk_q;
   logic [NCH-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed   <= 1'b0;
         clk_q    <= 1'b0;
         data_q   <= '0;
         edge_hit <= 1'b0;
         trans    <= '0;
      end else begin
         primed   <= 1'b1;
         clk_q    <= smp_clk;
         data_q   <= smp_data;
         edge_hit <= primed & ((smp_clk & ~clk_q & cfg_edge[0]) |
                               (~smp_clk & clk_q & cfg_edge[1]));
         trans    <= primed ? (smp_data ^ data_q) : '0;
      end
   end

   // R6: an edge event needs a level change and an enabled polarity
   p_edge_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |-> (clk_q != $past(clk_q)));
   p_edge_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |-> ($past(cfg_edge) != EDGE_NONE));
   // R9: no transition may be formed against the pre-reset register value
   p_trans_primed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (trans != '0) |-> $past(primed));
endmodule

// File: rtl/shd_history.sv
// Keeps transitions for PRE+POST+1 ticks and delays each edge event by POST ticks.
module shd_history #(
   parameter int NCH  = 8,
   parameter int PRE  = 64,
   parameter int POST = 64
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NCH-1:0]                  trans,
   input  logic                            edge_hit,
   output logic [PRE+POST:0][NCH-1:0]      hist,
   output logic                            edge_due
);
   localparam int DEPTH = PRE + POST + 1;

   logic [DEPTH-1:1][NCH-1:0] tr_sr;
   logic [POST:1]             edge_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tr_sr   <= '0;
         edge_sr <= '0;
      end else begin
         tr_sr[1]   <= trans;
         edge_sr[1] <= edge_hit;
         for (int i = 2; i < DEPTH; i++) tr_sr[i] <= tr_sr[i-1];
         for (int j = 2; j <= POST; j++) edge_sr[j] <= edge_sr[j-1];
      end
   end

   // index i holds the transition from i ticks ago
   always_comb begin
      hist[0] = trans;
      for (int i = 1; i < DEPTH; i++) hist[i] = tr_sr[i];
   end

   assign edge_due = edge_sr[POST];

   // R5: a due edge is the event captured one tick before in the line
   p_due_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      edge_sr[1] |-> $past(edge_hit));
endmodule

// File: rtl/shd_window.sv
// Selects history entries whose offset lies inside [cfg_setup, cfg_hold].
module shd_window #(
   parameter int NCH   = 8,
   parameter int PRE   = 64,
   parameter int POST  = 64,
   parameter int OFS_W = 8
) (
   input  logic [PRE+POST:0][NCH-1:0] hist,
   input  logic signed [OFS_W-1:0]    cfg_setup,
   input  logic signed [OFS_W-1:0]    cfg_hold,
   output logic [NCH-1:0]             hit_mask
);
   localparam int DEPTH = PRE + POST + 1;

   logic [DEPTH-1:0] sel;

   for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      localparam int K = POST - i;  // offset of this entry from the edge
      assign sel[i] = (K >= int'(cfg_setup)) && (K <= int'(cfg_hold));
   end

   always_comb begin
      hit_mask = '0;
      for (int i = 0; i < DEPTH; i++) hit_mask |= hist[i] & {NCH{sel[i]}};
   end

   // R4: an inverted window selects nothing
   always_comb begin
      if (cfg_setup > cfg_hold) p_empty_window_r4: assert (sel == '0);
   end
endmodule

// File: rtl/setup_hold_checker.sv
module setup_hold_checker #(
   parameter int NCH   = 8,
   parameter int PRE   = 64,
   parameter int POST  = 64,
   parameter int OFS_W = 8,
   parameter int CNT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_clk,
   input  logic [NCH-1:0]          smp_data,
   input  logic [1:0]              cfg_edge,
   input  logic signed [OFS_W-1:0] cfg_setup,
   input  logic signed [OFS_W-1:0] cfg_hold,
   output logic                    viol_valid,
   output logic                    viol_flag,
   output logic [NCH-1:0]          viol_mask,
   output logic [CNT_W-1:0]        viol_count
);
   localparam int              REACH   = (PRE > POST) ? PRE : POST;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (PRE < 1 || POST < 1) begin : g_bad_reach
      $error("PRE and POST must be at least 1");
   end
   if ((1 << (OFS_W - 1)) <= REACH) begin : g_bad_ofs
      $error("OFS_W too narrow for the look range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic                        edge_hit;
   logic [NCH-1:0]              trans;
   logic [PRE+POST:0][NCH-1:0]  hist;
   logic                        edge_due;
   logic [NCH-1:0]              hit_mask;

   shd_front #(.NCH(NCH)) u_front (
      .clk(clk), .rst_n(rst_n), .smp_clk(smp_clk), .smp_data(smp_data),
      .cfg_edge(cfg_edge), .edge_hit(edge_hit), .trans(trans)
   );

   shd_history #(.NCH(NCH), .PRE(PRE), .POST(POST)) u_hist (
      .clk(clk), .rst_n(rst_n), .trans(trans), .edge_hit(edge_hit),
      .hist(hist), .edge_due(edge_due)
   );

   shd_window #(.NCH(NCH), .PRE(PRE), .POST(POST), .OFS_W(OFS_W)) u_win (
      .hist(hist), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
      .hit_mask(hit_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_valid <= 1'b0;
         viol_flag  <= 1'b0;
         viol_mask  <= '0;
         viol_count <= '0;
      end else begin
         viol_valid <= edge_due;
         viol_flag  <= edge_due & (|hit_mask);
         viol_mask  <= edge_due ? hit_mask : '0;
         if (edge_due && (|hit_mask) && viol_count != CNT_MAX)
            viol_count <= viol_count + 1'b1;
      end
   end

   // R7: flag agrees with the registered mask
   p_flag_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> (viol_flag == (|viol_mask)));
   // R5: outside a result strobe the verdict outputs are quiet
   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !viol_valid |-> (viol_mask == '0 && !viol_flag));
   // R8: saturation holds
   p_count_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(viol_count) == CNT_MAX) |-> (viol_count == CNT_MAX));
   // R8: every change is a single step caused by a flagged result
   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_count != $past(viol_count)) |->
         (viol_valid && viol_flag && viol_count == CNT_W'($past(viol_count) + 1'b1)));
endmodule

// File: tb/sim_setup_hold_checker.sv
`timescale 1ns/1ps
module sim_setup_hold_checker;
   localparam int NCH = 4, PRE = 8, POST = 8, OFS_W = 5, CNT_W = 6;
   localparam int E = 15, TLEN = 40, NONE = 99;
   localparam int CMAX = (1 << CNT_W) - 1;

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic                    smp_clk;
   logic [NCH-1:0]          smp_data;
   logic [1:0]              cfg_edge;
   logic signed [OFS_W-1:0] cfg_setup, cfg_hold;
   logic                    viol_valid, viol_flag;
   logic [NCH-1:0]          viol_mask;
   logic [CNT_W-1:0]        viol_count;

   int checks = 0, errors = 0, ref_cnt = 0;
   bit finished = 0;
   logic cur_clk;
   logic [NCH-1:0] old;

   always #2 clk = ~clk;

   setup_hold_checker #(.NCH(NCH), .PRE(PRE), .POST(POST), .OFS_W(OFS_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_clk(smp_clk), .smp_data(smp_data),
      .cfg_edge(cfg_edge), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
      .viol_valid(viol_valid), .viol_flag(viol_flag), .viol_mask(viol_mask),
      .viol_count(viol_count)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit inwin(int k, int s, int h);
      return (k >= s) && (k <= h) && (k >= -PRE) && (k <= POST);
   endfunction

   // One edge with one transition per channel at offset a[c]; channel 0 may toggle back at g0.
   task automatic trial(input int s, input int h, input int a[NCH], input int g0, input string req);
      logic newc;
      bit   exp_v;
      logic [NCH-1:0] exp_m;
      string mreq;
      newc  = ~cur_clk;
      exp_v = newc ? cfg_edge[0] : cfg_edge[1];
      for (int c = 0; c < NCH; c++) exp_m[c] = inwin(a[c], s, h);
      if (g0 != NONE && inwin(g0, s, h)) exp_m[0] = 1'b1;
      mreq = (s > h) ? "R4" : req;
      @(negedge clk);
      cfg_setup = OFS_W'(s);
      cfg_hold  = OFS_W'(h);
      for (int t = 0; t < TLEN; t++) begin
         if (t > 0) @(negedge clk);
         if (t == E + POST + 2) begin
            check(viol_valid == exp_v, "R5", "valid at latency", viol_valid, exp_v);
            if (exp_v) begin
               check(viol_mask == exp_m, mreq, "mask", viol_mask, exp_m);
               check(viol_flag == (exp_m != 0), "R7", "flag", viol_flag, exp_m != 0);
               if (exp_m != 0 && ref_cnt < CMAX) ref_cnt++;
            end
            check(viol_count == ref_cnt, "R8", "count", viol_count, ref_cnt);
         end else begin
            check(viol_valid == 1'b0, "R5", "valid off latency", viol_valid, 0);
         end
         smp_clk = (t >= E) ? newc : cur_clk;
         for (int c = 0; c < NCH; c++) begin
            smp_data[c] = old[c] ^ (t >= E + a[c]);
            if (c == 0 && g0 != NONE) smp_data[c] = smp_data[c] ^ (t >= E + g0);
         end
      end
      cur_clk = smp_clk;
      old     = smp_data;
   endtask

   initial begin
      rst_n = 1'b0; smp_clk = 1'b1; smp_data = '1;
      cfg_edge = 2'b11; cfg_setup = '0; cfg_hold = '0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(viol_valid == 0, "R1", "valid", viol_valid, 0);
      check(viol_flag == 0, "R1", "flag", viol_flag, 0);
      check(viol_mask == 0, "R1", "mask", viol_mask, 0);
      check(viol_count == 0, "R1", "count", viol_count, 0);
      rst_n = 1'b1;
      // R9: high clock and data on the first sample must not look like an edge
      for (int i = 0; i < 2 * (PRE + POST); i++) begin
         @(negedge clk);
         check(viol_valid == 0, "R9", "startup valid", viol_valid, 0);
      end
      cur_clk = 1'b1; old = '1;

      // R2 and R4: every bound pair against transition offsets -9..+10
      for (int s = -9; s <= 9; s++)
         for (int h = -9; h <= 9; h++)
            for (int j = 0; j < 5; j++)
               trial(s, h, '{-9 + 4*j, -8 + 4*j, -7 + 4*j, -6 + 4*j}, NONE, "R2");

      // R3: offsets just beyond the look range with the widest window
      trial(-15, 15, '{-9, 9, -8, 8}, NONE, "R3");
      trial(-15, 15, '{-10, 10, NONE, NONE}, NONE, "R3");

      // R6: each polarity selection against a rising then a falling edge
      for (int m = 0; m < 4; m++) begin
         cfg_edge = 2'(m);
         trial(0, 0, '{0, NONE, NONE, NONE}, NONE, "R6");
         trial(0, 0, '{0, NONE, NONE, NONE}, NONE, "R6");
      end
      cfg_edge = 2'b11;

      // R10: two-tick pulse on channel 0 (changes at -3 and -1, or 0 and +2)
      trial(-3, -2, '{-3, NONE, NONE, NONE}, -1, "R10");
      trial(-2, -2, '{-3, NONE, NONE, NONE}, -1, "R10");
      trial(1, 2, '{0, NONE, NONE, NONE}, 2, "R10");

      // R8: the sweep violates far more often than the counter range
      check(viol_count == CMAX, "R8", "saturated count", viol_count, CMAX);

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule